// File: doc/BRIEF.md
# Processor Mode and Size Decoder

This block keeps a single registered status word that summarises how an x86-style core is currently executing. The word holds the operating mode, the submode, the current privilege level, the paging and protection flags, and the default sizes for operands, addresses and the stack. The block derives all of these from a small set of architectural control bits. These are the long-mode-active flag, the protection-enable and paging-enable control bits, three code-segment attributes, the stack-segment default-size flag, and the virtual-8086 flag.

The word does not track its inputs on every cycle. It is refreshed when the surrounding control logic pulses a refresh strobe, typically after writing one of the related control registers. It is also refreshed when the register bus writes to the status word's own address. That write carries no payload into this block. It only forces the word to be recomputed from the present inputs. Each refresh shows up on the output at the next rising clock edge.

Top module: `mode_status_decoder`

## Requirements
- R1: Bit 0 of the status word is the mode, where 1 means Long and 0 means Legacy. Bits [3:1] hold the submode, coded as 0 Real, 1 Protected, 2 Virtual-8086, 3 Compatibility and 4 64-bit. When long-mode-active is set, the mode is Long. The submode is then 64-bit if the code-segment long flag is set, and Compatibility if it is not.
- R2: When long-mode-active is clear, the mode is Legacy. The submode is Real if protection-enable is 0. It is Virtual-8086 if protection-enable is 1 and the virtual-8086 flag is 1. Otherwise it is Protected. The code-segment long flag has no effect in Legacy mode.
- R3: Bits [5:4] carry the code-segment privilege level. Bit 6 copies paging-enable and bit 7 copies protection-enable.
- R4: The operand size fields are bits [9:8] for the default size and [11:10] for the alternate size. Size codes are 1 for 16-bit, 2 for 32-bit and 3 for 64-bit. The fields are 2 and 1 in 64-bit submode or when the code-segment default-size flag is set. Otherwise they are 1 and 2.
- R5: The address size fields are bits [13:12] for the default size and [15:14] for the alternate size. They are 3 and 2 in 64-bit submode. Outside 64-bit submode they are 2 and 1 if the code-segment default-size flag is set, and 1 and 2 if it is clear.
- R6: Bits [17:16] hold the stack size. It is 3 in 64-bit submode. Outside 64-bit submode it is 2 if the stack-segment default-size flag is set, and 1 otherwise.
- R7: A cycle with the refresh strobe high loads the recomputed word, and the new word is visible after the next rising edge. Without a refresh trigger the word holds its value, whatever the inputs do.
- R8: A write strobe whose address equals SELF_ADDR forces the same recompute as the refresh strobe. A write to any other address leaves the word unchanged.
- R9: An active-low reset sets the word to Legacy/Real with privilege 0, paging and protection 0, and all five size fields set to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lma_i | input | 1 | Long-mode-active flag |
| pe_i | input | 1 | Protection-enable control bit |
| pg_i | input | 1 | Paging-enable control bit |
| vm_i | input | 1 | Virtual-8086 flag |
| cs_long_i | input | 1 | Code-segment 64-bit flag |
| cs_dsize_i | input | 1 | Code-segment default-size flag |
| cs_dpl_i | input | 2 | Code-segment privilege level |
| ss_dsize_i | input | 1 | Stack-segment default-size flag |
| refresh_i | input | 1 | Recompute strobe |
| wr_en_i | input | 1 | Register-bus write strobe |
| wr_addr_i | input | ADDR_W | Register-bus write address |
| status_o | output | 18 | Registered mode-status word |

## Verification
The bench targets the cases where one input has to be ignored. These are the code-segment long flag in Legacy mode, the virtual-8086 flag while protection is off, and both default-size flags in 64-bit submode. A design that leaked any of these would report 64-bit or Virtual-8086 submodes, or 32-bit sizes, where the rules forbid them. Real mode with the default-size flag set is also tested, so a design that pins Real mode to 16-bit fails. Writes to a neighbouring address and input changes without a trigger must leave the word frozen. A design that recomputes every cycle, or on any write, would show the new inputs early.

// File: rtl/msd_pkg.sv
package msd_pkg;

    typedef enum logic [2:0] {
        SUB_REAL   = 3'd0,
        SUB_PROT   = 3'd1,
        SUB_V86    = 3'd2,
        SUB_COMPAT = 3'd3,
        SUB_64     = 3'd4
    } submode_e;

    localparam int SZ_W = 2;
    localparam int DPL_W = 2;

    localparam logic [SZ_W-1:0] SZ_16 = 2'd1;
    localparam logic [SZ_W-1:0] SZ_32 = 2'd2;
    localparam logic [SZ_W-1:0] SZ_64 = 2'd3;

    typedef struct packed {
        logic [SZ_W-1:0] def_op;
        logic [SZ_W-1:0] alt_op;
        logic [SZ_W-1:0] def_addr;
        logic [SZ_W-1:0] alt_addr;
        logic [SZ_W-1:0] stack;
    } sizes_t;

    // Packed MSB first: bit 0 is the mode flag, bits 17:16 the stack size.
    typedef struct packed {
        logic [SZ_W-1:0]  stack;
        logic [SZ_W-1:0]  alt_addr;
        logic [SZ_W-1:0]  def_addr;
        logic [SZ_W-1:0]  alt_op;
        logic [SZ_W-1:0]  def_op;
        logic             prot;
        logic             paging;
        logic [DPL_W-1:0] cpl;
        submode_e         submode;
        logic             is_long;
    } status_t;

    localparam int STATUS_W = $bits(status_t);

    localparam status_t STATUS_RESET = '{
        stack:    SZ_16,
        alt_addr: SZ_16,
        def_addr: SZ_16,
        alt_op:   SZ_16,
        def_op:   SZ_16,
        prot:     1'b0,
        paging:   1'b0,
        cpl:      '0,
        submode:  SUB_REAL,
        is_long:  1'b0
    };

endpackage

// File: rtl/msd_mode_classify.sv
module msd_mode_classify
    import msd_pkg::*;
(
    input  logic     lma,
    input  logic     pe,
    input  logic     vm,
    input  logic     cs_long,
    output logic     is_long,
    output submode_e submode
);
    always_comb begin
        is_long = lma;
        if (lma) begin
            submode = cs_long ? SUB_64 : SUB_COMPAT;
        end else if (!pe) begin
            submode = SUB_REAL;
        end else if (vm) begin
            submode = SUB_V86;
        end else begin
            submode = SUB_PROT;
        end
    end
endmodule

// File: rtl/msd_size_select.sv
module msd_size_select
    import msd_pkg::*;
(
    input  logic   in_64,
    input  logic   cs_dsize,
    input  logic   ss_dsize,
    output sizes_t sizes
);
    always_comb begin
        // Operand size: 32-bit default in 64-bit submode or wide code segment.
        if (in_64 || cs_dsize) begin
            sizes.def_op = SZ_32;
            sizes.alt_op = SZ_16;
        end else begin
            sizes.def_op = SZ_16;
            sizes.alt_op = SZ_32;
        end

        // Address size: 64-bit submode wins over the segment flag.
        if (in_64) begin
            sizes.def_addr = SZ_64;
            sizes.alt_addr = SZ_32;
        end else if (cs_dsize) begin
            sizes.def_addr = SZ_32;
            sizes.alt_addr = SZ_16;
        end else begin
            sizes.def_addr = SZ_16;
            sizes.alt_addr = SZ_32;
        end

        // Stack width follows the stack segment outside 64-bit submode.
        if (in_64) begin
            sizes.stack = SZ_64;
        end else if (ss_dsize) begin
            sizes.stack = SZ_32;
        end else begin
            sizes.stack = SZ_16;
        end
    end
endmodule

// File: rtl/mode_status_decoder.sv
module mode_status_decoder
    import msd_pkg::*;
#(
    parameter int              ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] SELF_ADDR = 8'h40
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                lma_i,
    input  logic                pe_i,
    input  logic                pg_i,
    input  logic                vm_i,
    input  logic                cs_long_i,
    input  logic                cs_dsize_i,
    input  logic [1:0]          cs_dpl_i,
    input  logic                ss_dsize_i,
    input  logic                refresh_i,
    input  logic                wr_en_i,
    input  logic [ADDR_W-1:0]   wr_addr_i,
    output logic [17:0]         status_o
);
    status_t  status_d, status_q;
    logic     calc_long;
    submode_e calc_sub;
    sizes_t   calc_sizes;
    logic     trigger;

    msd_mode_classify u_classify (
        .lma     (lma_i),
        .pe      (pe_i),
        .vm      (vm_i),
        .cs_long (cs_long_i),
        .is_long (calc_long),
        .submode (calc_sub)
    );

    msd_size_select u_sizes (
        .in_64    (calc_sub == SUB_64),
        .cs_dsize (cs_dsize_i),
        .ss_dsize (ss_dsize_i),
        .sizes    (calc_sizes)
    );

    assign trigger = refresh_i || (wr_en_i && (wr_addr_i == SELF_ADDR));

    always_comb begin
        status_d = status_q;
        if (trigger) begin
            status_d.is_long  = calc_long;
            status_d.submode  = calc_sub;
            status_d.cpl      = cs_dpl_i;
            status_d.paging   = pg_i;
            status_d.prot     = pe_i;
            status_d.def_op   = calc_sizes.def_op;
            status_d.alt_op   = calc_sizes.alt_op;
            status_d.def_addr = calc_sizes.def_addr;
            status_d.alt_addr = calc_sizes.alt_addr;
            status_d.stack    = calc_sizes.stack;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= STATUS_RESET;
        end else begin
            status_q <= status_d;
        end
    end

    assign status_o = status_q;
endmodule

// File: rtl/msd_checker.sv
module msd_checker #(
    parameter int              ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] SELF_ADDR = 8'h40
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lma_i,
    input logic              pe_i,
    input logic              pg_i,
    input logic              cs_long_i,
    input logic              ss_dsize_i,
    input logic              refresh_i,
    input logic              wr_en_i,
    input logic [ADDR_W-1:0] wr_addr_i,
    input logic [17:0]       status_o
);
    logic self_wr;
    assign self_wr = wr_en_i && (wr_addr_i == SELF_ADDR);

    a_r1_long_64: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_i && lma_i && cs_long_i) |=> (status_o[0] && status_o[3:1] == 3'd4));

    a_r2_real_off: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_i && !lma_i && !pe_i) |=> (!status_o[0] && status_o[3:1] == 3'd0));

    a_r3_flag_copy: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_i |=> (status_o[6] == $past(pg_i) && status_o[7] == $past(pe_i)));

    a_r6_stack: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_i && !lma_i && ss_dsize_i) |=> (status_o[17:16] == 2'd2));

    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!refresh_i && !self_wr) |=> $stable(status_o));

    a_r8_self_write: assert property (@(posedge clk) disable iff (!rst_n)
        (self_wr && lma_i && cs_long_i) |=> (status_o[17:16] == 2'd3));
endmodule

bind mode_status_decoder msd_checker #(
    .ADDR_W    (ADDR_W),
    .SELF_ADDR (SELF_ADDR)
) u_msd_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .lma_i      (lma_i),
    .pe_i       (pe_i),
    .pg_i       (pg_i),
    .cs_long_i  (cs_long_i),
    .ss_dsize_i (ss_dsize_i),
    .refresh_i  (refresh_i),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .status_o   (status_o)
);

// File: tb/mode_status_decoder_bench.sv
module mode_status_decoder_bench;
    localparam int ADDR_W = 8;
    localparam logic [ADDR_W-1:0] SELF = 8'h40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lma, pe, pg, vm, csl, csd, ssd, refresh, wr_en;
    logic [1:0] dpl;
    logic [ADDR_W-1:0] wr_addr;
    logic [17:0] status;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    mode_status_decoder #(.ADDR_W(ADDR_W), .SELF_ADDR(SELF)) u_mode_status_decoder (
        .clk(clk), .rst_n(rst_n), .lma_i(lma), .pe_i(pe), .pg_i(pg), .vm_i(vm),
        .cs_long_i(csl), .cs_dsize_i(csd), .cs_dpl_i(dpl), .ss_dsize_i(ssd),
        .refresh_i(refresh), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .status_o(status)
    );

    // Inputs {lma,pe,pg,vm,cs_long,cs_dsize,dpl[1:0],ss_dsize}, then expected
    // {stack,alt_addr,def_addr,alt_op,def_op,prot,paging,cpl,submode,mode}.
    localparam int NV = 10;
    localparam logic [26:0] VEC [NV] = '{
        {9'b1_1_1_0_1_0_00_0, 2'd3,2'd2,2'd3,2'd1,2'd2,1'b1,1'b1,2'd0,3'd4,1'b1}, // R1 R4 R5 R6 64-bit
        {9'b1_1_1_0_1_1_11_1, 2'd3,2'd2,2'd3,2'd1,2'd2,1'b1,1'b1,2'd3,3'd4,1'b1}, // R6 flags ignored in 64
        {9'b1_1_1_0_0_1_11_1, 2'd2,2'd1,2'd2,2'd1,2'd2,1'b1,1'b1,2'd3,3'd3,1'b1}, // R1 compat 32
        {9'b1_1_1_0_0_0_00_0, 2'd1,2'd2,2'd1,2'd2,2'd1,1'b1,1'b1,2'd0,3'd3,1'b1}, // R1 compat 16
        {9'b0_0_0_1_1_0_00_0, 2'd1,2'd2,2'd1,2'd2,2'd1,1'b0,1'b0,2'd0,3'd0,1'b0}, // R2 real, vm/long ignored
        {9'b0_1_1_0_0_1_10_1, 2'd2,2'd1,2'd2,2'd1,2'd2,1'b1,1'b1,2'd2,3'd1,1'b0}, // R2 R3 protected 32
        {9'b0_1_0_1_0_0_11_0, 2'd1,2'd2,2'd1,2'd2,2'd1,1'b1,1'b0,2'd3,3'd2,1'b0}, // R2 v86
        {9'b0_1_0_0_1_0_01_1, 2'd2,2'd2,2'd1,2'd2,2'd1,1'b1,1'b0,2'd1,3'd1,1'b0}, // R2 R6 long flag ignored
        {9'b0_0_0_0_0_1_00_1, 2'd2,2'd1,2'd2,2'd1,2'd2,1'b0,1'b0,2'd0,3'd0,1'b0}, // R4 R5 real wide
        {9'b1_0_0_0_1_0_00_0, 2'd3,2'd2,2'd3,2'd1,2'd2,1'b0,1'b0,2'd0,3'd4,1'b1}  // R3 64 with flags off
    };

    localparam logic [17:0] RESET_WORD = {2'd1,2'd1,2'd1,2'd1,2'd1,1'b0,1'b0,2'd0,3'd0,1'b0};

    task automatic set_in(input logic [8:0] v);
        {lma, pe, pg, vm, csl, csd, dpl, ssd} = v;
    endtask

    task automatic check(input string req, input logic [17:0] exp);
        tests++;
        if (status !== exp) begin
            fails++;
            $display("FAIL %s: status=%h expected=%h", req, status, exp);
        end
    endtask

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog: timeout actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
        $finish;
    end

    initial begin
        set_in(9'b0);
        refresh = 1'b0; wr_en = 1'b0; wr_addr = '0;
        repeat (2) @(negedge clk);
        check("R9 reset word", RESET_WORD);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 reset word held", RESET_WORD);

        for (int i = 0; i < NV; i++) begin
            set_in(VEC[i][26:18]);
            refresh = 1'b1;
            @(negedge clk);
            refresh = 1'b0;
            check($sformatf("R1-R6 vector %0d", i), VEC[i][17:0]);
        end

        // R7: inputs change with no trigger; word must keep vector 9 value.
        set_in(VEC[4][26:18]);
        repeat (3) @(negedge clk);
        check("R7 hold without strobe", VEC[NV-1][17:0]);

        // R8: write to a neighbouring address does nothing.
        wr_en = 1'b1; wr_addr = SELF + 8'd1;
        @(negedge clk);
        wr_en = 1'b0;
        check("R8 other address ignored", VEC[NV-1][17:0]);

        // R8: write to own address recomputes from current inputs.
        wr_en = 1'b1; wr_addr = SELF;
        @(negedge clk);
        wr_en = 1'b0;
        check("R8 self write recompute", VEC[4][17:0]);

        // R7: recompute lands after exactly one edge.
        set_in(VEC[0][26:18]);
        refresh = 1'b1;
        #2;
        check("R7 no early update", VEC[4][17:0]);
        @(negedge clk);
        refresh = 1'b0;
        check("R7 one-edge latency", VEC[0][17:0]);

        // R9: reset mid-run returns to the reset word.
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 reset mid-run", RESET_WORD);
        rst_n = 1'b1;
        @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule